// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block collects interrupt requests from up to eight PCI devices and steers them onto sixteen ISA interrupt request outputs. Each requesting device gives its slot number, the interrupt pin it uses and a level. A fixed swizzle folds each (slot, pin) pair onto one of four shared PCI interrupt lines. The level of each shared line is the OR of every device request folded onto it.

Each of the four shared lines has an 8-bit steering register. A value below 16 names the ISA output that the line drives. A value of 16 or above leaves the line unconnected. An ISA output is high whenever any line steered to it is high. Software or a configuration agent loads the steering registers through a single-cycle write port, and a read port returns a selected register unchanged. The ISA outputs are combinational from the registers and the device levels, so a rewritten register moves a line's effect on the clock edge that stores it.

Top module: `irq_steer_top`

## Requirements
- R1: While reset is asserted and after it is released, every steering register reads 0x80 and all sixteen ISA outputs are low until a register is written.
- R2: A cycle with wrEn high stores wrData into the steering register selected by wrIdx (0 = line A through 3 = line D) at that clock edge. The other three registers keep their values.
- R3: rdData combinationally returns the full 8-bit value of the register selected by rdIdx, including the bits above bit 3, exactly as written.
- R4: A steering value v below 16 makes isaIrq[v] follow the level of that shared line.
- R5: A steering value of 16 to 255 makes that shared line drive no ISA output.
- R6: When several shared lines are steered to the same ISA output, that output is the OR of their levels.
- R7: A device in slot 10 folds onto line 3, slot 11 onto line 1 and slot 12 onto line 2, whatever its pin.
- R8: A device in slot 18, 19, 20 or 21 folds onto line ((slot - 18) + pin) mod 4.
- R9: A device in any other slot folds onto the line equal to its pin number.
- R10: The level of a shared line is the OR of the levels of all devices folded onto it. A device with a low level contributes nothing.
- R11: When a register is rewritten, the ISA output it previously selected drops in the cycle after the write edge unless another active line still selects it, and the newly selected output rises at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devSlot | input | 40 | Slot number of each device, 5 bits per device, device d in bits [5d+4:5d] |
| devPin | input | 16 | Interrupt pin of each device, 2 bits per device, device d in bits [2d+1:2d] |
| devLevel | input | 8 | Request level of each device, bit d for device d |
| wrEn | input | 1 | Write strobe for the steering registers |
| wrIdx | input | 2 | Index of the register to write |
| wrData | input | 8 | Value to write |
| rdIdx | input | 2 | Index of the register to read |
| rdData | output | 8 | Value of the selected register |
| isaIrq | output | 16 | ISA interrupt request levels |

## Verification
A register rewrite and a change in device levels can fall in the same cycle. The new steering value and the new request pattern then both decide the ISA outputs of the next cycle. The random phase drives fresh slots, pins and levels on every cycle and writes a random register on about half of those cycles. It also picks steering values from a narrow pool so that shared ISA targets and out-of-range values both come up often. After each edge the bench compares all sixteen outputs with a model that applies the write first and then folds and merges the current requests. A stale register, or a merge that keeps only one source, shows as a mismatch on the shared output.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  localparam int LINE_CNT = 4;
  localparam int LINE_W   = 2;
  localparam int SLOT_W   = 5;
  localparam int REG_W    = 8;

  localparam logic [REG_W-1:0] ROUTE_RESET = 8'h80;

  localparam logic [SLOT_W-1:0] FIXED_SLOT_A = 5'd10;
  localparam logic [SLOT_W-1:0] FIXED_SLOT_B = 5'd11;
  localparam logic [SLOT_W-1:0] FIXED_SLOT_C = 5'd12;
  localparam logic [SLOT_W-1:0] ROT_SLOT_LO  = 5'd18;
  localparam logic [SLOT_W-1:0] ROT_SLOT_HI  = 5'd21;

  typedef struct packed {
    logic [LINE_CNT-1:0] load;
    logic [REG_W-1:0]    value;
  } steer_strobe_t;

  // Fold a device (slot, pin) onto one of the shared lines.
  function automatic logic [LINE_W-1:0] foldLine(input logic [SLOT_W-1:0] slot,
                                                 input logic [LINE_W-1:0] pin);
    logic [SLOT_W-1:0] offs;
    offs = slot - ROT_SLOT_LO;
    if (slot == FIXED_SLOT_A)      foldLine = 2'd3;
    else if (slot == FIXED_SLOT_B) foldLine = 2'd1;
    else if (slot == FIXED_SLOT_C) foldLine = 2'd2;
    else if (slot >= ROT_SLOT_LO && slot <= ROT_SLOT_HI)
      foldLine = offs[LINE_W-1:0] + pin;
    else
      foldLine = pin;
  endfunction

endpackage

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [LINE_W-1:0]         wrIdx,
  input  logic [REG_W-1:0]          wrData,
  output steer_strobe_t             strb
);

  logic [LINE_CNT-1:0] loadVec;

  for (genvar k = 0; k < LINE_CNT; k++) begin : g_dec
    assign loadVec[k] = wrEn && (wrIdx == LINE_W'(k));
  end

  assign strb.load  = loadVec;
  assign strb.value = wrData;

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.load));

  // R2
  strobe_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (strb.load != '0));

endmodule

// File: rtl/irq_steer_datapath.sv
module irq_steer_datapath
  import irq_steer_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int NUM_ISA = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  steer_strobe_t             strb,
  input  logic [NUM_DEV*SLOT_W-1:0] devSlot,
  input  logic [NUM_DEV*LINE_W-1:0] devPin,
  input  logic [NUM_DEV-1:0]        devLevel,
  input  logic [LINE_W-1:0]         rdIdx,
  output logic [REG_W-1:0]          rdData,
  output logic [NUM_ISA-1:0]        isaIrq
);

  localparam int ISA_IDX_W = $clog2(NUM_ISA);

  logic [REG_W-1:0]    routeReg [LINE_CNT];
  logic [LINE_W-1:0]   devLine  [NUM_DEV];
  logic [LINE_CNT-1:0] lineLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < LINE_CNT; k++) routeReg[k] <= ROUTE_RESET;
    end else begin
      for (int k = 0; k < LINE_CNT; k++)
        if (strb.load[k]) routeReg[k] <= strb.value;
    end
  end

  assign rdData = routeReg[rdIdx];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_fold
    assign devLine[d] = foldLine(devSlot[d*SLOT_W +: SLOT_W], devPin[d*LINE_W +: LINE_W]);
  end

  always_comb begin
    lineLevel = '0;
    for (int d = 0; d < NUM_DEV; d++)
      if (devLevel[d]) lineLevel[devLine[d]] = 1'b1;
  end

  always_comb begin
    isaIrq = '0;
    for (int k = 0; k < LINE_CNT; k++)
      if (routeReg[k] < REG_W'(NUM_ISA))
        isaIrq[routeReg[k][ISA_IDX_W-1:0]] = isaIrq[routeReg[k][ISA_IDX_W-1:0]] | lineLevel[k];
  end

  for (genvar k = 0; k < LINE_CNT; k++) begin : g_chk
    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.load[k] |=> (routeReg[k] == $past(strb.value)));
    // R2
    load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.load[k] |=> $stable(routeReg[k]));
  end

  // R6
  isa_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(isaIrq) <= LINE_CNT);

  // R10
  isa_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|isaIrq) |-> (|devLevel));

endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int NUM_ISA = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_DEV*SLOT_W-1:0] devSlot,
  input  logic [NUM_DEV*LINE_W-1:0] devPin,
  input  logic [NUM_DEV-1:0]        devLevel,
  input  logic                      wrEn,
  input  logic [LINE_W-1:0]         wrIdx,
  input  logic [REG_W-1:0]          wrData,
  input  logic [LINE_W-1:0]         rdIdx,
  output logic [REG_W-1:0]          rdData,
  output logic [NUM_ISA-1:0]        isaIrq
);

  steer_strobe_t strb;

  irq_steer_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .strb   (strb)
  );

  irq_steer_datapath #(.NUM_DEV(NUM_DEV), .NUM_ISA(NUM_ISA)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .devSlot  (devSlot),
    .devPin   (devPin),
    .devLevel (devLevel),
    .rdIdx    (rdIdx),
    .rdData   (rdData),
    .isaIrq   (isaIrq)
  );

endmodule

// File: tb/irq_steer_top_test.sv
module irq_steer_top_test;

  localparam int ND = 8;
  localparam int NI = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [ND*5-1:0] devSlot = '0;
  logic [ND*2-1:0] devPin = '0;
  logic [ND-1:0] devLevel = '0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrIdx = '0;
  logic [7:0]    wrData = '0;
  logic [1:0]    rdIdx = '0;
  logic [7:0]    rdData;
  logic [NI-1:0] isaIrq;

  logic [7:0] model [4];
  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_steer_top uut (
    .clk(clk), .rstN(rstN), .devSlot(devSlot), .devPin(devPin), .devLevel(devLevel),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .rdIdx(rdIdx), .rdData(rdData),
    .isaIrq(isaIrq)
  );

  function automatic int refLine(int slot, int pin);
    if (slot == 10) return 3;
    if (slot == 11) return 1;
    if (slot == 12) return 2;
    if (slot >= 18 && slot <= 21) return (slot - 18 + pin) % 4;
    return pin;
  endfunction

  function automatic logic [NI-1:0] refIsa();
    logic [3:0] lv;
    logic [NI-1:0] o;
    lv = '0;
    o = '0;
    for (int d = 0; d < ND; d++)
      if (devLevel[d]) lv[refLine(int'(devSlot[d*5 +: 5]), int'(devPin[d*2 +: 2]))] = 1'b1;
    for (int k = 0; k < 4; k++)
      if (model[k] < 16 && lv[k]) o[model[k][3:0]] = 1'b1;
    return o;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive on negedge, model the write at posedge, check mid-high phase
  task automatic cyc(bit we, logic [1:0] idx, logic [7:0] val);
    @(negedge clk);
    wrEn = we; wrIdx = idx; wrData = val;
    @(posedge clk);
    if (we) model[idx] = val;
    #5;
    wrEn = 1'b0;
  endtask

  task automatic setDev(int d, int slot, int pin, bit lvl);
    devSlot[d*5 +: 5] = 5'(slot);
    devPin[d*2 +: 2]  = 2'(pin);
    devLevel[d]       = lvl;
  endtask

  task automatic readAll(string req);
    for (int k = 0; k < 4; k++) begin
      rdIdx = 2'(k);
      #1;
      chk(req, 32'(rdData), 32'(model[k]));
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) model[k] = 8'h80;
    for (int d = 0; d < ND; d++) setDev(d, 0, 0, 1'b1);
    #45;
    // R1 during reset: all devices active yet outputs low
    readAll("R1");
    chk("R1", 32'(isaIrq), 32'h0);
    rstN = 1'b1;
    cyc(0, 0, 0);
    chk("R1", 32'(isaIrq), 32'h0);
    readAll("R1");
    devLevel = '0;

    // R3 full value readback, R2 others unchanged
    cyc(1, 2, 8'hA5);
    readAll("R3");
    // R4 steer lines 0..3 to outputs 4..7
    for (int k = 0; k < 4; k++) cyc(1, 2'(k), 8'(4 + k));
    readAll("R2");

    // R7 fixed slots
    setDev(0, 10, 0, 1); cyc(0, 0, 0); chk("R7", 32'(isaIrq), 32'h0080);
    setDev(0, 11, 3, 1); cyc(0, 0, 0); chk("R7", 32'(isaIrq), 32'h0020);
    setDev(0, 12, 1, 1); cyc(0, 0, 0); chk("R7", 32'(isaIrq), 32'h0040);
    // R8 rotating slots
    setDev(0, 18, 3, 1); cyc(0, 0, 0); chk("R8", 32'(isaIrq), 32'h0080);
    setDev(0, 21, 2, 1); cyc(0, 0, 0); chk("R8", 32'(isaIrq), 32'h0020);
    setDev(0, 19, 0, 1); cyc(0, 0, 0); chk("R8", 32'(isaIrq), 32'h0020);
    // R9 pass-through
    setDev(0, 5, 2, 1);  cyc(0, 0, 0); chk("R9", 32'(isaIrq), 32'h0040);
    setDev(0, 22, 0, 1); cyc(0, 0, 0); chk("R9", 32'(isaIrq), 32'h0010);
    // R10 inactive device contributes nothing; two devices OR
    setDev(0, 5, 2, 0); cyc(0, 0, 0); chk("R10", 32'(isaIrq), 32'h0);
    setDev(1, 10, 0, 1); setDev(2, 20, 1, 1); cyc(0, 0, 0);
    chk("R10", 32'(isaIrq), 32'h0080);

    // R6 merge: all lines to output 9, only line 2 active
    devLevel = '0;
    for (int k = 0; k < 4; k++) cyc(1, 2'(k), 8'd9);
    setDev(0, 12, 0, 1); cyc(0, 0, 0); chk("R6", 32'(isaIrq), 32'h0200);
    setDev(1, 11, 0, 1); cyc(0, 0, 0); chk("R6", 32'(isaIrq), 32'h0200);

    // R5 disconnect with 0x10 and 0xFF
    cyc(1, 2, 8'h10); chk("R5", 32'(isaIrq), 32'h0200);
    cyc(1, 1, 8'hFF); chk("R5", 32'(isaIrq), 32'h0);

    // R11 rewrite moves output on the edge
    devLevel = '0;
    setDev(0, 0, 0, 1);
    cyc(1, 0, 8'd3); chk("R11", 32'(isaIrq), 32'h0008);
    cyc(1, 0, 8'd5); chk("R11", 32'(isaIrq), 32'h0020);
    // R11 shared target stays up while another line still drives it
    setDev(1, 0, 3, 1);
    cyc(1, 3, 8'd5); chk("R11", 32'(isaIrq), 32'h0020);
    cyc(1, 0, 8'd12); chk("R11", 32'(isaIrq), 32'h1020);

    // Random: writes concurrent with request changes (R4 R6 R10 R11)
    void'($urandom(32'h5EED));
    for (int n = 0; n < 400; n++) begin
      logic [7:0] pool [6];
      pool = '{8'd0, 8'd3, 8'd3, 8'd15, 8'd16, 8'hC7};
      for (int d = 0; d < ND; d++)
        setDev(d, int'($urandom_range(0, 31)), int'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 1) == 1) begin
        logic [7:0] v;
        v = ($urandom_range(0, 3) == 0) ? 8'($urandom) : pool[$urandom_range(0, 5)];
        cyc(1, 2'($urandom_range(0, 3)), v);
      end else begin
        cyc(0, 0, 0);
      end
      chk("R4", 32'(isaIrq), 32'(refIsa()));
      if (n % 16 == 0) readAll("R3");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule